// File: doc/BRIEF.md
# Masked Set/Clear GPIO Register Port

This block is a memory-mapped bank of 32-bit general-purpose I/O ports. Each port owns a direction register, a write-protect mask, an output latch, and three ways to change that latch: a direct load through the pin window, a write-one-to-set window and a write-one-to-clear window. Reading the pin window returns the external input level after a two-flop synchronizer, not the latch.

Each register can be reached as a full word, as either half-word or as any single byte. A bus master can therefore change one lane of a port without a read-modify-write and without disturbing the other lanes. A per-pin alternate-function select takes a pin away from the port. While it is asserted, that pin's output enable is dropped and the port cannot change its latch bit.

Top module: `gpio_mset_port`

## Requirements
- R1: After reset every direction, mask and latch bit is 0, so pin_out and pin_oe are all 0 and every register reads 0.
- R2: The direction register sits at port offset 0x00. pin_oe for a bit is its direction bit (1 = output) gated low by that pin's alt_sel bit, and pin_out is the output latch.
- R3: A write to the set window (offset 0x18) sets each latch bit written with 1 and leaves bits written with 0 unchanged. A read of this window returns the latch.
- R4: A write to the clear window (offset 0x1C) clears each latch bit written with 1 and leaves bits written with 0 unchanged. A read of this window returns 0.
- R5: A write to the pin window (offset 0x14) loads the written value into every writable latch bit of the selected lanes.
- R6: A latch bit is writable only when its mask bit is 0, its direction bit is 1 and its alt_sel bit is 0. Pin, set and clear writes leave every other latch bit unchanged.
- R7: A read of the pin window returns pin_in through two flops, with masked bits reading 0. A change on pin_in becomes readable after the second rising clock edge, not the first.
- R8: bus_size encodes 0 = byte, 1 = half-word, 2 = word. A byte access at register base + n (n = 0..3) covers bits 8n..8n+7. A half-word access at base + 0 covers bits 15:0 and one at base + 2 covers bits 31:16. Write data is taken right-justified from bus_wdata, and only the covered bits change.
- R9: A read returns the covered bits right-justified in bus_rdata, with all higher bits 0.
- R10: An access is ignored (no register changes, read returns 0) when bus_size is 3, a half-word address is odd, a word address is not a multiple of 4, or the offset names no register.
- R11: Port p occupies addresses p*0x20 to p*0x20+0x1F. A write to one port never changes another port.
- R12: The mask register sits at offset 0x10, is fully writable and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (6) | Byte address within the block |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wr | input | 1 | Write strobe, committed at the next rising edge |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Right-justified, zero-extended read data (combinational) |
| alt_sel | input | 32*NPORTS | Per-pin alternate-function select |
| pin_in | input | 32*NPORTS | External pin levels (asynchronous) |
| pin_out | output | 32*NPORTS | Output latch per pin |
| pin_oe | output | 32*NPORTS | Output enable per pin |

## Verification
The bench sweeps every offset and every size in both port windows. After each write it compares all registers and pins against an arithmetic model, so a lane decoder that widened a byte write to its neighbour, or accepted an odd half-word address, shows up as a changed bit outside the addressed lane. Directed cases target write gating under mask, input direction and alternate function: a design that forgot one of these terms would set protected latch bits. They also check that the clear window reads zero, that the set window returns the latch rather than the pin, and that a pin_in change is still invisible one edge after it occurs. A shortened synchronizer would show the new level one cycle early.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W    = 32;
  localparam int LANE_W    = 8;
  localparam int NLANES    = PORT_W / LANE_W;
  localparam int WIN_BITS  = 5;   // 32-byte window per port
  localparam int OFF_DIR   = 0;
  localparam int OFF_MASK  = 4;   // word index 0x10
  localparam int OFF_PIN   = 5;   // word index 0x14
  localparam int OFF_SET   = 6;   // word index 0x18
  localparam int OFF_CLR   = 7;   // word index 0x1C

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_DIR,
    RG_MASK,
    RG_PIN,
    RG_SET,
    RG_CLR
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] chain_d;
    if (s == 0) begin : g_first
      assign chain_d = d_async;
    end else begin : g_next
      assign chain_d = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_d;
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int PIDX_W = 1,
  parameter int ADDR_W = WIN_BITS + PIDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [PORT_W-1:0] wdata,
  output logic              hit,
  output reg_sel_e          sel,
  output logic [PIDX_W-1:0] port_idx,
  output logic [1:0]        lane_off,
  output logic [1:0]        size_q,
  output logic [PORT_W-1:0] bit_en,
  output logic [PORT_W-1:0] wdata_al
);
  logic [2:0]        word_idx;
  logic              align_ok;
  logic              port_ok;
  logic [NLANES-1:0] lanes;
  reg_sel_e          sel_raw;

  assign word_idx = addr[WIN_BITS-1:2];
  assign lane_off = addr[1:0];
  assign port_idx = addr[ADDR_W-1 -: PIDX_W];
  assign port_ok  = (int'(port_idx) < NPORTS);
  assign size_q   = size;

  always_comb begin
    unique case (int'(word_idx))
      OFF_DIR:  sel_raw = RG_DIR;
      OFF_MASK: sel_raw = RG_MASK;
      OFF_PIN:  sel_raw = RG_PIN;
      OFF_SET:  sel_raw = RG_SET;
      OFF_CLR:  sel_raw = RG_CLR;
      default:  sel_raw = RG_NONE;
    endcase
  end

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: begin
        align_ok = 1'b1;
        lanes    = NLANES'(1) << lane_off;
      end
      SZ_HALF: begin
        align_ok = ~lane_off[0];
        lanes    = NLANES'(3) << lane_off;
      end
      SZ_WORD: begin
        align_ok = (lane_off == 2'd0);
        lanes    = '1;
      end
      default: begin
        align_ok = 1'b0;
        lanes    = '0;
      end
    endcase
  end

  assign hit = align_ok & port_ok & (sel_raw != RG_NONE);
  assign sel = hit ? sel_raw : RG_NONE;

  for (genvar b = 0; b < PORT_W; b++) begin : g_be
    assign bit_en[b] = hit & lanes[b / LANE_W];
  end

  assign wdata_al = wdata << {lane_off, 3'b000};
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [PORT_W-1:0] bit_en,
  input  logic [PORT_W-1:0] wdata_al,
  input  logic [PORT_W-1:0] alt_sel,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] rd_word
);
  logic [PORT_W-1:0] dir_q,  dir_d;
  logic [PORT_W-1:0] mask_q, mask_d;
  logic [PORT_W-1:0] lat_q,  lat_d;
  logic [PORT_W-1:0] ok_bits, wr_bits, in_sync;
  logic              dir_en, mask_en, lat_en;

  gpio_sync #(.W(PORT_W), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (in_sync)
  );

  // Next-state logic
  assign ok_bits = ~mask_q & dir_q & ~alt_sel;
  assign wr_bits = bit_en & ok_bits;
  assign dir_en  = wr_en && (sel == RG_DIR);
  assign mask_en = wr_en && (sel == RG_MASK);
  assign lat_en  = wr_en && (sel == RG_PIN || sel == RG_SET || sel == RG_CLR);

  always_comb begin
    dir_d  = (dir_q  & ~bit_en) | (wdata_al & bit_en);
    mask_d = (mask_q & ~bit_en) | (wdata_al & bit_en);
    unique case (sel)
      RG_PIN:  lat_d = (lat_q & ~wr_bits) | (wdata_al & wr_bits);
      RG_SET:  lat_d = lat_q | (wdata_al & wr_bits);
      RG_CLR:  lat_d = lat_q & ~(wdata_al & wr_bits);
      default: lat_d = lat_q;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  // Read and pin side
  always_comb begin
    unique case (sel)
      RG_DIR:  rd_word = dir_q;
      RG_MASK: rd_word = mask_q;
      RG_PIN:  rd_word = in_sync & ~mask_q;
      RG_SET:  rd_word = lat_q;
      default: rd_word = '0;
    endcase
  end

  assign pin_out = lat_q;
  assign pin_oe  = dir_q & ~alt_sel;

  // R6: protected latch bits never move on a latch write
  assert_blocked_bits_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lat_en |=> ((lat_q & $past(~ok_bits)) == ($past(lat_q) & $past(~ok_bits))));

  // R3: every writable bit written with 1 through the set window ends high
  assert_set_goes_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RG_SET) |=>
      ((lat_q & $past(wdata_al & wr_bits)) == $past(wdata_al & wr_bits)));

  // R4: every writable bit written with 1 through the clear window ends low
  assert_clear_goes_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RG_CLR) |=> ((lat_q & $past(wdata_al & wr_bits)) == '0));
endmodule

// File: rtl/gpio_mset_port.sv
module gpio_mset_port
  import gpio_pkg::*;
#(
  parameter  int NPORTS = 2,
  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int ADDR_W = WIN_BITS + PIDX_W,
  localparam int PINS   = NPORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   alt_sel,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  logic              rst_sync_n;
  logic              hit;
  reg_sel_e          sel;
  logic [PIDX_W-1:0] port_idx;
  logic [1:0]        lane_off;
  logic [1:0]        size_q;
  logic [PORT_W-1:0] bit_en, wdata_al;
  logic [PORT_W-1:0] rd_words [NPORTS];
  logic [PORT_W-1:0] rd_sel, rd_shift, size_mask;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_addr_dec #(.NPORTS(NPORTS), .PIDX_W(PIDX_W), .ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .size     (bus_size),
    .wdata    (bus_wdata),
    .hit      (hit),
    .sel      (sel),
    .port_idx (port_idx),
    .lane_off (lane_off),
    .size_q   (size_q),
    .bit_en   (bit_en),
    .wdata_al (wdata_al)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic wr_here;
    assign wr_here = bus_wr & hit & (int'(port_idx) == p);
    gpio_port u_port (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_en    (wr_here),
      .sel      (sel),
      .bit_en   (bit_en),
      .wdata_al (wdata_al),
      .alt_sel  (alt_sel[p*PORT_W +: PORT_W]),
      .pin_in   (pin_in[p*PORT_W +: PORT_W]),
      .pin_out  (pin_out[p*PORT_W +: PORT_W]),
      .pin_oe   (pin_oe[p*PORT_W +: PORT_W]),
      .rd_word  (rd_words[p])
    );
  end

  // Read alignment: pick port, shift selected lane down, zero the rest
  always_comb begin
    rd_sel = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (hit && int'(port_idx) == p) rd_sel = rd_words[p];
    end
  end

  always_comb begin
    unique case (acc_size_e'(size_q))
      SZ_BYTE: size_mask = PORT_W'({LANE_W{1'b1}});
      SZ_HALF: size_mask = PORT_W'({2*LANE_W{1'b1}});
      default: size_mask = '1;
    endcase
  end

  assign rd_shift  = rd_sel >> {lane_off, 3'b000};
  assign bus_rdata = rd_shift & size_mask;

  // R9: a byte read never carries data above bit 7
  assert_byte_read_zext_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_size == SZ_BYTE) |-> (bus_rdata[PORT_W-1:LANE_W] == '0));

  // R10: a rejected write changes no output latch
  assert_bad_access_no_write_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && !hit) |=> $stable(pin_out));
endmodule

// File: tb/sim_gpio_mset_port.sv
`timescale 1ns/1ps
module sim_gpio_mset_port;
  localparam int NP = 2;

  logic        clk;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic [1:0]  bus_size;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] alt_sel;
  logic [63:0] pin_in;
  logic [63:0] pin_out;
  logic [63:0] pin_oe;

  gpio_mset_port #(.NPORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alt_sel(alt_sel), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m_dir  [NP];
  logic [31:0] m_mask [NP];
  logic [31:0] m_lat  [NP];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic bit acc_ok(input int off, input int sz);
    int w = off / 4;
    bit reg_ok = (w == 0) || (w == 4) || (w == 5) || (w == 6) || (w == 7);
    bit al;
    if (sz == 0)      al = 1;
    else if (sz == 1) al = (off % 2) == 0;
    else if (sz == 2) al = (off % 4) == 0;
    else              al = 0;
    return reg_ok && al;
  endfunction

  function automatic logic [31:0] width_mask(input int sz);
    if (sz == 0) return 32'h0000_00FF;
    if (sz == 1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic model_write(input int p, input int off, input int sz, input logic [31:0] data);
    int bo = off % 4;
    logic [31:0] be, wd, ok;
    if (!acc_ok(off, sz)) return;
    be = width_mask(sz) << (8 * bo);
    wd = data << (8 * bo);
    ok = ~m_mask[p] & m_dir[p] & ~alt_sel[p*32 +: 32];
    case (off / 4)
      0: m_dir[p]  = (m_dir[p]  & ~be) | (wd & be);
      4: m_mask[p] = (m_mask[p] & ~be) | (wd & be);
      5: m_lat[p]  = (m_lat[p] & ~(be & ok)) | (wd & be & ok);
      6: m_lat[p]  = m_lat[p] | (wd & be & ok);
      7: m_lat[p]  = m_lat[p] & ~(wd & be & ok);
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input int p, input int off, input int sz);
    logic [31:0] w;
    if (!acc_ok(off, sz)) return 32'h0;
    case (off / 4)
      0: w = m_dir[p];
      4: w = m_mask[p];
      5: w = pin_in[p*32 +: 32] & ~m_mask[p];
      6: w = m_lat[p];
      default: w = 32'h0;
    endcase
    return (w >> (8 * (off % 4))) & width_mask(sz);
  endfunction

  task automatic bus_write(input int p, input int off, input int sz, input logic [31:0] data);
    @(negedge clk);
    bus_addr  = 6'(p * 32 + off);
    bus_size  = 2'(sz);
    bus_wdata = data;
    bus_wr    = 1'b1;
    model_write(p, off, sz, data);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int p, input int off, input int sz, output logic [31:0] val);
    @(negedge clk);
    bus_wr   = 1'b0;
    bus_addr = 6'(p * 32 + off);
    bus_size = 2'(sz);
    #1;
    val = bus_rdata;
  endtask

  task automatic read_check(input string tag, input int p, input int off, input int sz);
    logic [31:0] v;
    bus_read(p, off, sz, v);
    check(tag, v, model_read(p, off, sz));
  endtask

  task automatic pins_check(input string tag);
    for (int p = 0; p < NP; p++) begin
      check({tag, " pin_out"}, pin_out[p*32 +: 32], m_lat[p]);
      check({tag, " pin_oe"},  pin_oe[p*32 +: 32],  m_dir[p] & ~alt_sel[p*32 +: 32]);
    end
  endtask

  task automatic regs_check(input string tag, input int p);
    read_check(tag, p, 8'h00, 2);
    read_check(tag, p, 8'h10, 2);
    read_check(tag, p, 8'h14, 2);
    read_check(tag, p, 8'h18, 2);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_size = 2'd2; bus_wr = 1'b0;
    bus_wdata = '0; alt_sel = '0; pin_in = '0;
    for (int p = 0; p < NP; p++) begin
      m_dir[p] = '0; m_mask[p] = '0; m_lat[p] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int p = 0; p < NP; p++) begin
      bus_read(p, 8'h00, 2, v); check("R1 dir", v, 32'h0);
      bus_read(p, 8'h10, 2, v); check("R1 mask", v, 32'h0);
      bus_read(p, 8'h18, 2, v); check("R1 latch", v, 32'h0);
    end
    check("R1 pin_out", pin_out[31:0], 32'h0);
    check("R1 pin_oe",  pin_oe[31:0],  32'h0);

    // R12: mask read-back
    bus_write(0, 8'h10, 2, 32'h0000_00F0);
    bus_read(0, 8'h10, 2, v); check("R12 mask", v, 32'h0000_00F0);

    // R2: direction and alternate function on output enable
    alt_sel = 64'h0000_0000_0000_0F00;
    bus_write(0, 8'h00, 2, 32'hFFFF_FFFF);
    check("R2 pin_oe", pin_oe[31:0], 32'hFFFF_F0FF);

    // R3: set window
    bus_write(0, 8'h18, 2, 32'hA5A5_A5A5);
    bus_read(0, 8'h18, 2, v); check("R3 set", v, 32'hA5A5_A005);
    check("R3 pin_out", pin_out[31:0], 32'hA5A5_A005);
    bus_write(0, 8'h18, 2, 32'h0000_0000);
    bus_read(0, 8'h18, 2, v); check("R3 zero no effect", v, 32'hA5A5_A005);
    // R6: protected bits (mask 7:4, alt 11:8) untouched by set of all ones
    bus_write(0, 8'h18, 2, 32'hFFFF_FFFF);
    bus_read(0, 8'h18, 2, v); check("R6 protected", v & 32'h0000_0FF0, 32'h0);

    // R4: clear window, reads zero
    bus_write(0, 8'h1C, 2, 32'h0000_FFFF);
    bus_read(0, 8'h18, 2, v); check("R4 clear", v, 32'hFFFF_0000);
    bus_read(0, 8'h1C, 2, v); check("R4 clear reads 0", v, 32'h0);

    // R5: direct load through pin window
    bus_write(0, 8'h14, 2, 32'h1234_5678);
    bus_read(0, 8'h18, 2, v); check("R5 pin load", v, 32'h1234_5008);

    // R6: input-direction bits are protected
    bus_write(0, 8'h00, 2, 32'h0000_FFFF);
    bus_write(0, 8'h18, 2, 32'hFFFF_FFFF);
    bus_read(0, 8'h18, 2, v); check("R6 input dir", v, 32'h1234_F00F);

    // R7: two-flop synchronizer latency, masked bits read 0
    @(negedge clk);
    pin_in[31:0] = 32'hDEAD_BEEF;
    bus_addr = 6'h14; bus_size = 2'd2; bus_wr = 1'b0;
    @(negedge clk); #1;
    check("R7 one edge", bus_rdata, 32'h0);
    @(negedge clk); #1;
    check("R7 two edges", bus_rdata, 32'hDEAD_BE0F);

    // R10: rejected accesses
    bus_write(0, 8'h19, 1, 32'h0000_FFFF);
    check("R10 odd half write", pin_out[31:0], m_lat[0]);
    bus_read(0, 8'h19, 1, v); check("R10 odd half read", v, 32'h0);
    bus_write(0, 8'h1A, 2, 32'hFFFF_FFFF);
    check("R10 unaligned word write", pin_out[31:0], m_lat[0]);
    bus_write(0, 8'h04, 2, 32'hFFFF_FFFF);
    bus_read(0, 8'h04, 2, v); check("R10 hole read", v, 32'h0);
    bus_read(0, 8'h18, 3, v); check("R10 size 3 read", v, 32'h0);

    // R11: port independence
    bus_write(1, 8'h18, 2, 32'hFFFF_FFFF);
    check("R11 port1 input", pin_out[63:32], 32'h0);
    bus_write(1, 8'h00, 2, 32'hFFFF_FFFF);
    bus_write(1, 8'h18, 2, 32'h0F0F_0F0F);
    check("R11 port1 set", pin_out[63:32], 32'h0F0F_0F0F);
    check("R11 port0 kept", pin_out[31:0], 32'h1234_F00F);

    // R8: sub-word writes touch only their lanes
    bus_write(0, 8'h02, 0, 32'h0000_003C);
    bus_read(0, 8'h00, 2, v); check("R8 byte dir", v, 32'h003C_FFFF);
    bus_write(0, 8'h12, 1, 32'h0000_BEEF);
    bus_read(0, 8'h10, 2, v); check("R8 half mask", v, 32'hBEEF_00F0);
    // R9: lane read right-justified
    bus_read(0, 8'h1B, 0, v); check("R9 byte read", v, 32'h0000_0012);
    bus_read(0, 8'h12, 1, v); check("R9 half read", v, 32'h0000_BEEF);

    // R8 sweep: every port, offset and size written, all state compared
    alt_sel = 64'h00F0_0000_0000_F00F;
    pin_in  = 64'h5A5A_C3C3_0FF0_9669;
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      for (int off = 0; off < 32; off++) begin
        for (int sz = 0; sz < 4; sz++) begin
          int k = (p * 32 + off) * 4 + sz;
          logic [31:0] d = (32'h9E37_79B9 * 32'(k + 1)) ^ 32'(k << 13);
          bus_write(p, off, sz, d);
          regs_check("R8 sweep", p);
          pins_check("R8 sweep");
        end
      end
    end

    // R9 sweep: every alias read compared with the model
    for (int p = 0; p < NP; p++)
      for (int off = 0; off < 32; off++)
        for (int sz = 0; sz < 4; sz++)
          read_check("R9 sweep", p, off, sz);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule